// File: doc/BRIEF.md
# Dual-Rail HDB3/AMI Line Decoder with Error and Alarm Flags

This block receives a ternary line signal on two rails, one for positive marks and one for negative marks, on the rising edge of a receive clock. It recovers the binary NRZ stream with a fixed latency of four clock periods. An `hdb3_mode` input selects one of two modes. In HDB3 mode the decoder spots polarity violations that close a substituted zero run and turns that run back into zeros. In AMI mode it reports every violation as a coding error.

An error flag is raised, in line with the affected output bit, for AMI violations and for the illegal state where both rails are high. A separate alarm flag tracks line activity. It counts received spaces across the two most recent periods marked by an external single-cycle strobe, and it goes high when too few spaces were seen.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: Both rails are sampled on the rising clock edge. A symbol with either rail high is a mark and decodes to 1, and a space decodes to 0. The decoded bit appears on `nrz_out` after the fourth rising edge that follows the sampling edge.
- R2: A violation is a single-rail mark whose polarity equals that of the previous single-rail mark. The first single-rail mark after reset is never a violation. A both-rails-high symbol does not change the stored polarity.
- R3: With `hdb3_mode` = 1, a violation is a substitution when, among the four symbols received just before it, the oldest is a mark and the two newest are spaces. The violation and the three symbols before it are then output as 0.
- R4: With `hdb3_mode` = 1, a violation that is not a substitution is output as 1, and `err_out` stays low for it.
- R5: With `hdb3_mode` = 0, every violation is output as 1 with `err_out` high, and no substitution is ever removed.
- R6: In either mode, a symbol with both rails high decodes as 1 and sets `err_out` high for that bit. The bit is still cleared to 0 if R3 later applies to it.
- R7: `err_out` has the same four-edge latency as `nrz_out` and refers to the bit shown beside it.
- R8: `ais_out` changes only on an edge where `alarm_strobe` is sampled high. At that edge it takes the value 1 when fewer than three spaces were received in total across two periods: the period ending with the strobe cycle (strobe cycle included) and the period before it. Otherwise it takes 0. The period before the first strobe after reset counts from reset.
- R9: While `rst_n` is low, all outputs are 0 and the polarity, symbol and space-count history is cleared. For the first four edges after release, `nrz_out` and `err_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; rails sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdb3_mode | input | 1 | 1 selects HDB3 decoding, 0 selects AMI |
| rail_p | input | 1 | Positive-mark rail |
| rail_n | input | 1 | Negative-mark rail |
| alarm_strobe | input | 1 | Single-cycle pulse closing an alarm counting period |
| nrz_out | output | 1 | Recovered NRZ bit |
| err_out | output | 1 | Coding error flag aligned with `nrz_out` |
| ais_out | output | 1 | Low-space-count alarm |

## Verification
A symbol sampled at edge k has its data bit and error flag on the outputs after edge k+4. The bench keeps a per-symbol expected array and compares that entry four symbol steps after driving it. This gives any later substitution time to clear the entry first. The alarm result is due after the strobe edge itself, so the bench compares it at the falling edge after every symbol, and it also confirms that the flag holds between strobes. All comparisons are made at falling edges, half a period away from the edges that update the outputs.

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder #(
  parameter int AIS_ZEROS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hdb3_mode,
  input  logic rail_p,
  input  logic rail_n,
  input  logic alarm_strobe,
  output logic nrz_out,
  output logic err_out,
  output logic ais_out
);
  localparam int CW = $clog2(AIS_ZEROS + 1);
  localparam logic [CW-1:0] CMAX = CW'(AIS_ZEROS);

  logic mark, single, both, viol, subst, space;
  logic last_pos, pol_seen;
  logic [3:0] hist, dpipe, epipe;
  logic nrz_q, err_q, ais_q;
  logic [CW-1:0] cur_cnt, prev_cnt, cur_inc;
  logic [CW:0] pair_sum;

  assign mark   = rail_p | rail_n;
  assign single = rail_p ^ rail_n;
  assign both   = rail_p & rail_n;
  assign space  = ~mark;
  assign viol   = single & pol_seen & (rail_p == last_pos);
  assign subst  = hdb3_mode & viol & hist[3] & ~hist[1] & ~hist[0];

  assign cur_inc  = (space && cur_cnt != CMAX) ? cur_cnt + CW'(1) : cur_cnt;
  assign pair_sum = {1'b0, prev_cnt} + {1'b0, cur_inc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pos <= 1'b0;
      pol_seen <= 1'b0;
      hist     <= '0;
      dpipe    <= '0;
      epipe    <= '0;
      nrz_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      hist  <= {hist[2:0], mark};
      epipe <= {epipe[2:0], both | (~hdb3_mode & viol)};
      if (subst) dpipe <= '0;
      else       dpipe <= {dpipe[2:0], mark};
      nrz_q <= dpipe[3];
      err_q <= epipe[3];
      if (single) begin
        last_pos <= rail_p;
        pol_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_cnt  <= '0;
      prev_cnt <= '0;
      ais_q    <= 1'b0;
    end else if (alarm_strobe) begin
      ais_q    <= pair_sum < (CW+1)'(AIS_ZEROS);
      prev_cnt <= cur_inc;
      cur_cnt  <= '0;
    end else begin
      cur_cnt <= cur_inc;
    end
  end

  assign nrz_out = nrz_q;
  assign err_out = err_q;
  assign ais_out = ais_q;
endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic hdb3_mode,
  input logic rail_p,
  input logic rail_n,
  input logic alarm_strobe,
  input logic nrz_out,
  input logic err_out,
  input logic ais_out
);
  logic [2:0] warm;
  logic ready;

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 3'd6) warm <= warm + 3'd1;
  end
  assign ready = (warm == 3'd6);

  AST_SPACE_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(!rail_p && !rail_n, 5)) |-> (!nrz_out && !err_out)); // R1
  AST_BOTH_RAILS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(rail_p && rail_n, 5)) |-> err_out); // R6
  AST_HDB3_SINGLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(hdb3_mode && (rail_p ^ rail_n), 5)) |-> !err_out); // R4
  AST_AMI_MARK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(!hdb3_mode && (rail_p || rail_n), 5) && $past(!hdb3_mode, 4)
     && $past(!hdb3_mode, 3) && $past(!hdb3_mode, 2)) |-> nrz_out); // R5
  AST_AIS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_strobe |=> $stable(ais_out)); // R8
endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdb3_mode(hdb3_mode), .rail_p(rail_p),
  .rail_n(rail_n), .alarm_strobe(alarm_strobe), .nrz_out(nrz_out),
  .err_out(err_out), .ais_out(ais_out)
);

// File: tb/sim_hdb3_rx_decoder.sv
module sim_hdb3_rx_decoder;
  localparam int NS = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdb3_mode = 1'b1;
  logic rail_p = 1'b0;
  logic rail_n = 1'b0;
  logic alarm_strobe = 1'b0;
  logic nrz_out, err_out, ais_out;

  always #10 clk = ~clk;

  hdb3_rx_decoder u0 (
    .clk(clk), .rst_n(rst_n), .hdb3_mode(hdb3_mode), .rail_p(rail_p),
    .rail_n(rail_n), .alarm_strobe(alarm_strobe), .nrz_out(nrz_out),
    .err_out(err_out), .ais_out(ais_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit e_nrz [NS];
  bit e_err [NS];
  bit rmark [NS];
  string tg [NS];
  int sidx = 0;
  int rstart = 0;
  bit m_lp, m_pv, e_ais;
  int m_cur, m_prev;

  task automatic chk(input bit got, input bit exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at symbol %0d: got %0b expected %0b", tag, what, sidx, got, exp);
    end
  endtask

  function automatic bit hm(input int i);
    return (i >= rstart) ? rmark[i] : 1'b0;
  endfunction

  task automatic model(input bit p, input bit n, input bit mode, input bit stb);
    bit mk, sg, bh, vi, sb;
    int inc;
    mk = p | n; sg = p ^ n; bh = p & n;
    vi = sg && m_pv && (p == m_lp);
    sb = mode && vi && hm(sidx-4) && !hm(sidx-2) && !hm(sidx-1);
    rmark[sidx] = mk;
    e_nrz[sidx] = mk;
    e_err[sidx] = bh | (!mode & vi);
    tg[sidx] = bh ? "R6" : (vi ? (mode ? "R2 R4" : "R2 R5") : "R1");
    if (sb) begin
      for (int k = sidx-3; k <= sidx; k++) begin
        e_nrz[k] = 1'b0;
        tg[k] = "R3";
      end
    end
    if (sg) begin m_lp = p; m_pv = 1'b1; end
    inc = (!mk && m_cur < 3) ? m_cur + 1 : m_cur;
    if (stb) begin
      e_ais = (m_prev + inc) < 3;
      m_prev = inc;
      m_cur = 0;
    end else m_cur = inc;
  endtask

  task automatic sym(input bit p, input bit n, input bit mode, input bit stb);
    rail_p = p; rail_n = n; hdb3_mode = mode; alarm_strobe = stb;
    model(p, n, mode, stb);
    @(posedge clk); @(negedge clk);
    if (sidx - 4 >= rstart) begin
      chk(nrz_out, e_nrz[sidx-4], tg[sidx-4], "nrz");
      chk(err_out, e_err[sidx-4], {tg[sidx-4], " R7"}, "err");
    end else begin
      chk(nrz_out, 1'b0, "R9", "nrz after reset");
      chk(err_out, 1'b0, "R9", "err after reset");
    end
    chk(ais_out, e_ais, "R8", "ais");
    sidx++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rail_p = 0; rail_n = 0; alarm_strobe = 0;
    repeat (3) @(negedge clk);
    chk(nrz_out, 1'b0, "R9", "nrz in reset");
    chk(err_out, 1'b0, "R9", "err in reset");
    chk(ais_out, 1'b0, "R9", "ais in reset");
    rst_n = 1'b1;
    m_lp = 0; m_pv = 0; m_cur = 0; m_prev = 0; e_ais = 0;
    rstart = sidx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int zp, cd, r;
    bit md, s;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // HDB3 directed: B000V, B00V, plain violation, both rails
    sym(1,0,1,0); sym(0,0,1,0); sym(0,0,1,0); sym(0,0,1,0); sym(1,0,1,0);
    sym(0,1,1,0); sym(0,0,1,0); sym(0,0,1,0); sym(0,1,1,0);
    sym(1,0,1,0); sym(1,0,1,0); sym(0,1,1,0); sym(1,1,1,0); sym(0,1,1,0);
    // BB00V
    sym(1,0,1,0); sym(0,1,1,0); sym(0,0,1,0); sym(0,0,1,0); sym(0,1,1,0);
    // AMI directed: violation and a would-be substitution
    sym(1,0,0,0); sym(0,0,0,0); sym(0,0,0,0); sym(0,0,0,0); sym(1,0,0,0);
    sym(1,1,0,0); sym(1,0,0,1); sym(0,0,0,0); sym(0,0,0,1);
    sym(0,0,0,0); sym(0,0,0,0); sym(0,0,0,0); sym(0,0,0,0);
    // reset clears polarity: positive then positive after reset is not a violation
    sym(1,0,0,0);
    do_reset();
    sym(1,0,0,0); sym(0,0,0,0); sym(0,0,0,0); sym(0,0,0,0);
    sym(0,0,0,0); sym(0,0,0,0);
    // random segments
    cd = 5;
    for (int seg = 0; seg < 80; seg++) begin
      r = $urandom_range(0, 3);
      zp = (r == 0) ? 0 : (r == 1) ? 15 : (r == 2) ? 50 : 80;
      md = ($urandom_range(0, 3) != 0);
      for (int j = 0; j < 50; j++) begin
        s = (cd == 0);
        cd = s ? $urandom_range(2, 9) : cd - 1;
        r = $urandom_range(0, 99);
        if (r < zp) sym(0, 0, md, s);
        else begin
          r = $urandom_range(0, 19);
          if (r == 0) sym(1, 1, md, s);
          else if (r < 10) sym(1, 0, md, s);
          else sym(0, 1, md, s);
        end
      end
    end
    for (int j = 0; j < 6; j++) sym(0, 0, 1, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule